// File: doc/BRIEF.md
# Video Channel Gamma Lookup Stage

This stage sits on one video channel and remaps each sample through a programmable table, for example to apply gamma correction. The upper bits of the incoming sample address a table of 13-bit entries. When the table is switched on, the stored entry leaves the stage in place of the sample. When it is switched off, the sample leaves the stage untouched.

The stage has two modes: PASS, where the sample travels through unchanged, and TABLE, where the looked-up entry replaces it. A mode is carried down the pipeline alongside each sample. The transition PASS to TABLE (the enable goes high with a sample) and the transition TABLE to PASS (the enable goes low with a sample) both act on exactly that sample and leave every sample ahead of it alone. Both modes take the same two clock cycles, so switching the table in or out never changes the alignment with other channels.

A host write port loads table entries one per cycle. Each channel has a single table, and the enable decides whether that table is in the path. Reset clears the pipeline but not the table, so the table must be loaded before TABLE mode gives meaningful results.

Top module: `gamma_lut_stage`

## Requirements
- R1: The table holds 1024 entries of 13 bits, and every entry can be written by the host and read back through a lookup.
- R2: In TABLE mode (`lut_on` = 1 with the sample) the entry reaches `pix_out` exactly 2 clock cycles after the sample is presented on `pix_in`.
- R3: In PASS mode (`lut_on` = 0 with the sample) `pix_out` equals the sample, unchanged, exactly 2 clock cycles after it was presented.
- R4: The table address is `pix_in[12:3]`, the 10 most significant bits of the 13-bit sample. Bits `pix_in[2:0]` have no effect on the result in TABLE mode.
- R5: In TABLE mode the output is the table entry stored at the sample's address, in place of the sample.
- R6: While `rst` is high (synchronous, active high), `pix_out` is zero from the first clock edge of reset onwards.
- R7: `lut_on` is registered together with each sample, so consecutive samples may use different modes and each takes its own mode.
- R8: A host write (`host_we` = 1, `host_addr`, `host_data`) takes effect on the next cycle. A lookup of that address presented one cycle after the write returns the new entry.
- R9: If a host write and a lookup target the same address in the same cycle, the lookup returns the entry held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline and the table |
| rst | input | 1 | Synchronous active-high reset of the pipeline registers |
| lut_on | input | 1 | Mode for the current sample: 1 = TABLE, 0 = PASS |
| pix_in | input | 13 | Incoming video sample; bits 12:3 address the table |
| host_we | input | 1 | Host table write strobe |
| host_addr | input | 10 | Host table write address |
| host_data | input | 13 | Host table write data |
| pix_out | output | 13 | Outgoing sample, two cycles after its input |

## Verification
The hardest case to produce from the ports is a host write and a lookup that meet on one address. When they meet in the same cycle, the old entry must come out. When the write comes one cycle earlier, the new entry must come out. The bench keeps a model table that it updates only after it has computed the expected value for the sample driven in the same cycle. It then drives both orderings against an address whose old and new entries differ. Full sweeps cover the rest: every address in TABLE mode with the low sample bits varied, bypass traffic during the table load, alternating modes, and a reset in the middle of a stream.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

    // Operating mode carried alongside each sample
    typedef enum logic {
        MODE_PASS  = 1'b0,
        MODE_TABLE = 1'b1
    } lut_mode_e;

endpackage

// File: rtl/gamma_lut_ram.sv
module gamma_lut_ram #(
    parameter int ADDR_W  = 10,
    parameter int ENTRY_W = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Table storage: host writes, no reset (contents defined by host)
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read; same-edge write is not yet visible (old entry)
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/gamma_lut_align.sv
module gamma_lut_align
    import gamma_lut_pkg::*;
#(
    parameter int SAMPLE_W = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_en,
    input  logic [SAMPLE_W-1:0] sample_in,
    output lut_mode_e           mode_q,
    output logic [SAMPLE_W-1:0] sample_q
);
    lut_mode_e mode_d;

    always_comb begin
        mode_d = mode_en ? MODE_TABLE : MODE_PASS;
    end

    // First pipeline stage: hold sample and its mode beside the table read
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_PASS;
            sample_q <= '0;
        end else begin
            mode_q   <= mode_d;
            sample_q <= sample_in;
        end
    end
endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage
    import gamma_lut_pkg::*;
#(
    parameter int SAMPLE_W = 13,
    parameter int ADDR_W   = 10,
    parameter int ENTRY_W  = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lut_on,
    input  logic [SAMPLE_W-1:0] pix_in,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [ENTRY_W-1:0]  host_data,
    output logic [ENTRY_W-1:0]  pix_out
);
    localparam int ADDR_LSB = SAMPLE_W - ADDR_W;

    logic [ADDR_W-1:0]   lk_addr;
    logic [ENTRY_W-1:0]  tbl_q;
    lut_mode_e           mode_q;
    logic [SAMPLE_W-1:0] sample_q;
    logic [ENTRY_W-1:0]  out_d;

    assign lk_addr = pix_in[SAMPLE_W-1:ADDR_LSB];

    gamma_lut_ram #(
        .ADDR_W  (ADDR_W),
        .ENTRY_W (ENTRY_W)
    ) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_we),
        .wr_addr (host_addr),
        .wr_data (host_data),
        .rd_addr (lk_addr),
        .rd_data (tbl_q)
    );

    gamma_lut_align #(
        .SAMPLE_W (SAMPLE_W)
    ) u_align (
        .clk       (clk),
        .rst       (rst),
        .mode_en   (lut_on),
        .sample_in (pix_in),
        .mode_q    (mode_q),
        .sample_q  (sample_q)
    );

    // Mode-driven output selection
    always_comb begin
        unique case (mode_q)
            MODE_TABLE: out_d = tbl_q;
            MODE_PASS:  out_d = ENTRY_W'(sample_q);
            default:    out_d = '0;
        endcase
    end

    // Second pipeline stage: output register
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out <= '0;
        end else begin
            pix_out <= out_d;
        end
    end
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
    parameter int SAMPLE_W = 13,
    parameter int ADDR_W   = 10,
    parameter int ENTRY_W  = 13
) (
    input logic                clk,
    input logic                rst,
    input logic                lut_on,
    input logic [SAMPLE_W-1:0] pix_in,
    input logic                host_we,
    input logic [ADDR_W-1:0]   host_addr,
    input logic [ENTRY_W-1:0]  host_data,
    input logic [ENTRY_W-1:0]  pix_out
);
    localparam int ADDR_LSB = SAMPLE_W - ADDR_W;

    logic [2:0] run_cnt;
    logic       seen_edge;
    logic [ADDR_W-1:0] in_addr;

    assign in_addr = pix_in[SAMPLE_W-1:ADDR_LSB];

    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        if (rst) begin
            run_cnt <= '0;
        end else if (run_cnt != 3'd7) begin
            run_cnt <= run_cnt + 3'd1;
        end
    end

    // R3: bypassed sample appears unchanged two cycles later
    a_r3_bypass_delay: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 3'd3 && !$past(lut_on, 2)) |-> (pix_out == ENTRY_W'($past(pix_in, 2))));

    // R6: output is zero after an edge in reset
    a_r6_reset_zero: assert property (@(posedge clk)
        (seen_edge && $past(rst)) |-> (pix_out == '0));

    // R8: a write is seen by a lookup presented one cycle later
    a_r8_write_then_read: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 3'd4 && $past(host_we, 3) && $past(lut_on, 2) &&
         $past(in_addr, 2) == $past(host_addr, 3))
        |-> (pix_out == $past(host_data, 3)));

    // R4: repeated address in table mode with no intervening write gives a steady output
    a_r4_low_bits_ignored: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 3'd5 && $past(lut_on, 2) && $past(lut_on, 3) &&
         $past(in_addr, 2) == $past(in_addr, 3) && !$past(host_we, 3))
        |-> $stable(pix_out));
endmodule

bind gamma_lut_stage gamma_lut_chk #(
    .SAMPLE_W (SAMPLE_W),
    .ADDR_W   (ADDR_W),
    .ENTRY_W  (ENTRY_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lut_on    (lut_on),
    .pix_in    (pix_in),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_data (host_data),
    .pix_out   (pix_out)
);

// File: tb/gamma_lut_stage_test.sv
module gamma_lut_stage_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lut_on = 1'b0;
    logic [12:0] pix_in = '0;
    logic        host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [12:0] host_data = '0;
    logic [12:0] pix_out;

    int n_checks = 0;
    int n_fail   = 0;

    logic [12:0] mdl [1024];
    logic [12:0] epipe [2];
    logic        vpipe [2];
    string       tpipe [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    gamma_lut_stage uut (
        .clk       (clk),
        .rst       (rst),
        .lut_on    (lut_on),
        .pix_in    (pix_in),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_data (host_data),
        .pix_out   (pix_out)
    );

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pix_out actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one sample (and optional host write) at the falling edge,
    // checking the output belonging to the sample two cycles earlier.
    task automatic step(input logic [12:0] s, input logic en, input logic we,
                        input logic [9:0] wa, input logic [12:0] wd, input string tag);
        @(negedge clk);
        if (vpipe[1]) check(tpipe[1], pix_out, epipe[1]);
        vpipe[1] = vpipe[0];
        epipe[1] = epipe[0];
        tpipe[1] = tpipe[0];
        epipe[0] = en ? mdl[s[12:3]] : s;
        vpipe[0] = 1'b1;
        tpipe[0] = tag;
        if (we) mdl[wa] = wd;
        pix_in    = s;
        lut_on    = en;
        host_we   = we;
        host_addr = wa;
        host_data = wd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        host_we = 1'b0;
        lut_on = 1'b0;
        pix_in = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R6", pix_out, 13'h0000);
        vpipe[0] = 1'b0;
        vpipe[1] = 1'b0;
        rst = 1'b0;
    endtask

    function automatic logic [12:0] tbl_val(input int i);
        return 13'((i * 37 + 11) & 13'h1FFF);
    endfunction

    initial begin
        vpipe[0] = 1'b0;
        vpipe[1] = 1'b0;
        do_reset();

        // Load table while bypass traffic flows (R1 load, R3 bypass)
        for (int i = 0; i < 1024; i++) begin
            step(13'((i * 101 + 3) & 13'h1FFF), 1'b0, 1'b1, 10'(i), tbl_val(i), "R3");
        end

        // Full address sweep in TABLE mode, low bits varied (R1, R2, R4, R5)
        for (int i = 0; i < 1024; i++) begin
            step({10'(i), 3'(i * 5)}, 1'b1, 1'b0, '0, '0, "R1_R2_R5");
        end

        // Same address, every low-bit value (R4)
        for (int b = 0; b < 8; b++) begin
            step({10'd700, 3'(b)}, 1'b1, 1'b0, '0, '0, "R4");
        end

        // Alternating mode sample by sample (R7)
        for (int i = 0; i < 64; i++) begin
            step(13'((i * 523 + 77) & 13'h1FFF), 1'(i & 1), 1'b0, '0, '0, "R7");
        end

        // Same-cycle write and lookup returns old entry (R9)
        step({10'd5, 3'd2}, 1'b1, 1'b1, 10'd5, 13'h1ABC, "R9");
        // Lookup one cycle after write returns new entry (R8)
        step({10'd5, 3'd6}, 1'b1, 1'b0, '0, '0, "R8");
        step({10'd1023, 3'd0}, 1'b1, 1'b1, 10'd1023, 13'h0F0F, "R9");
        step({10'd1023, 3'd7}, 1'b1, 1'b0, '0, '0, "R8");
        step({10'd0, 3'd1}, 1'b1, 1'b1, 10'd0, 13'h1FFF, "R9");
        step({10'd0, 3'd1}, 1'b1, 1'b0, '0, '0, "R8");

        // Flush, then reset mid-stream (R6)
        step(13'h1234, 1'b0, 1'b0, '0, '0, "R3");
        step(13'h0567, 1'b0, 1'b0, '0, '0, "R3");
        step(13'h0000, 1'b0, 1'b0, '0, '0, "R3");
        step(13'h0000, 1'b0, 1'b0, '0, '0, "R3");
        step(13'h1FFF, 1'b1, 1'b0, '0, '0, "R2");
        do_reset();

        // Short run after reset: both modes (R2, R3)
        step(13'h0AAA, 1'b0, 1'b0, '0, '0, "R3");
        step({10'd300, 3'd4}, 1'b1, 1'b0, '0, '0, "R2");
        step(13'h1555, 1'b0, 1'b0, '0, '0, "R3");
        step(13'h0000, 1'b0, 1'b0, '0, '0, "R3");
        step(13'h0000, 1'b0, 1'b0, '0, '0, "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule